// File: doc/BRIEF.md
# Reverse-Direction Tape Word Corrector

This block sits on the word path between a tape word assembler and the host data register. It has two independent channels. The read channel carries words from the tape towards the host. The write channel carries words from the host towards the tape. Each word is 12 bits wide by default and is made of four 3-bit digits.

A tape that runs backward delivers each word in complement-obverse form. This means the digit order is mirrored and every bit is inverted. When correction is switched on, the block applies the same transform to every word tagged as reverse, and that undoes the damage. The host then sees true values, although the words still arrive in reverse order. When correction is off, reverse words pass raw. This is the older behaviour, and software written for raw reverse data relies on it. Forward words are never touched.

Software loads the correction mode through a one-cycle load strobe. The mode is captured together with the direction flag at the moment each word is accepted, so a change only ever applies from a word boundary onward. Each channel is a single registered stage under a valid/ready handshake.

Top module: `revcorr_top`

## Requirements
- R1: A read word accepted with its reverse flag low appears on the read output with exactly the value it had at the input.
- R2: A read word accepted with its reverse flag high while correction is on appears transformed. Split the input into 3-bit digits d3 d2 d1 d0, with d0 in bits 2:0. The output is digits (7-d0)(7-d1)(7-d2)(7-d3), with the first of these in bits 11:9. For example, octal 1234 becomes octal 3456.
- R3: A read word accepted with its reverse flag high while correction is off appears unchanged.
- R4: After reset, correction is off.
- R5: A pulse on modeLoad sets correction to modeValue. The new mode applies only to words accepted after the clock edge that loads it. A word accepted on that same edge uses the previous mode.
- R6: The reverse flag and the mode are sampled when a word is accepted. Changing either input while the word waits at the output does not alter that word.
- R7: A word accepted on a clock edge is valid at the output directly after that edge. The output word holds stable while it is valid and not taken.
- R8: An input is not ready while its output holds a word that is not being taken. No accepted word is lost, and none is duplicated.
- R9: The write channel follows R1, R2, R3, R6, R7 and R8 on its own ports. Its stalls are independent of the read channel.
- R10: A word corrected once and then corrected again returns its original value. This holds for a word passed reverse through the read channel and then reverse through the write channel.
- R11: While reset is held, both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | One-cycle strobe that loads the correction mode |
| modeValue | input | 1 | Mode value to load (1 = correct reverse words) |
| rdInValid | input | 1 | A tape word is offered |
| rdInReady | output | 1 | The read channel can take a word |
| rdInData | input | 12 | Word assembled from the tape |
| rdInReverse | input | 1 | The tape moved backward for this word |
| rdOutValid | output | 1 | A word for the host is held |
| rdOutReady | input | 1 | The host takes the held word |
| rdOutData | output | 12 | Word presented to the host |
| wrInValid | input | 1 | A host word is offered for writing |
| wrInReady | output | 1 | The write channel can take a word |
| wrInData | input | 12 | Word from the host |
| wrInReverse | input | 1 | The tape moves backward while this word is written |
| wrOutValid | output | 1 | A word for the tape is held |
| wrOutReady | input | 1 | The tape writer takes the held word |
| wrOutData | output | 12 | Word sent to the tape |

## Verification
Every word that is accepted is due at its channel's output one clock edge later. It stays there for as long as the output is stalled.

The bench drives inputs and reads ready on the falling edge. It pushes the word's expected value into a per-channel queue, computed from the mode and direction in force at acceptance. A monitor pops and compares the queue on every falling edge where the output is valid and taken. Explicit checks on the falling edge right after acceptance pin down the single-edge latency. Mid-stall changes to direction and mode are held against the already-queued value.

// File: rtl/revcorr_pkg.sv
package revcorr_pkg;
  localparam int CHAN_N = 2;
  localparam int CH_RD = 0;
  localparam int CH_WR = 1;

  typedef struct packed {
    logic [CHAN_N-1:0] load;   // capture a new word into the channel register
    logic [CHAN_N-1:0] flip;   // apply the obverse-complement transform
  } corrStrobe_t;
endpackage

// File: rtl/revcorr_ctl.sv
module revcorr_ctl
  import revcorr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic              modeValue,
  input  logic [CHAN_N-1:0] inValid,
  input  logic [CHAN_N-1:0] inReverse,
  input  logic [CHAN_N-1:0] outReady,
  output logic [CHAN_N-1:0] inReady,
  output logic [CHAN_N-1:0] outValid,
  output corrStrobe_t       strb
);
  logic corrOn;

  // mode register: resets to the compatible (raw) setting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         corrOn <= 1'b0;
    else if (modeLoad) corrOn <= modeValue;
  end

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    logic accept;
    assign inReady[c]   = !outValid[c] || outReady[c];
    assign accept       = inValid[c] && inReady[c];
    assign strb.load[c] = accept;
    assign strb.flip[c] = inReverse[c] && corrOn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            outValid[c] <= 1'b0;
      else if (accept)      outValid[c] <= 1'b1;
      else if (outReady[c]) outValid[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/revcorr_dp.sv
module revcorr_dp
  import revcorr_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int GRP_N = 4,
  localparam int WORD_W = GRP_W * GRP_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  corrStrobe_t       strb,
  input  logic [WORD_W-1:0] rdInData,
  input  logic [WORD_W-1:0] wrInData,
  output logic [WORD_W-1:0] rdOutData,
  output logic [WORD_W-1:0] wrOutData
);
  logic [CHAN_N-1:0][WORD_W-1:0] inWord;
  logic [CHAN_N-1:0][WORD_W-1:0] heldWord;

  assign inWord[CH_RD] = rdInData;
  assign inWord[CH_WR] = wrInData;

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    logic [WORD_W-1:0] obverse;
    logic [WORD_W-1:0] nextWord;

    // mirror digit order, invert every bit; applying it twice is identity
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      assign obverse[(GRP_N-1-g)*GRP_W +: GRP_W] = ~inWord[c][g*GRP_W +: GRP_W];
    end

    assign nextWord = strb.flip[c] ? obverse : inWord[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             heldWord[c] <= '0;
      else if (strb.load[c]) heldWord[c] <= nextWord;
    end
  end

  assign rdOutData = heldWord[CH_RD];
  assign wrOutData = heldWord[CH_WR];
endmodule

// File: rtl/revcorr_top.sv
module revcorr_top
  import revcorr_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int GRP_N = 4,
  localparam int WORD_W = GRP_W * GRP_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic              modeValue,
  input  logic              rdInValid,
  output logic              rdInReady,
  input  logic [WORD_W-1:0] rdInData,
  input  logic              rdInReverse,
  output logic              rdOutValid,
  input  logic              rdOutReady,
  output logic [WORD_W-1:0] rdOutData,
  input  logic              wrInValid,
  output logic              wrInReady,
  input  logic [WORD_W-1:0] wrInData,
  input  logic              wrInReverse,
  output logic              wrOutValid,
  input  logic              wrOutReady,
  output logic [WORD_W-1:0] wrOutData
);
  corrStrobe_t       strb;
  logic [CHAN_N-1:0] inReady;
  logic [CHAN_N-1:0] outValid;

  revcorr_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .modeLoad  (modeLoad),
    .modeValue (modeValue),
    .inValid   ({wrInValid, rdInValid}),
    .inReverse ({wrInReverse, rdInReverse}),
    .outReady  ({wrOutReady, rdOutReady}),
    .inReady   (inReady),
    .outValid  (outValid),
    .strb      (strb)
  );

  revcorr_dp #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdInData  (rdInData),
    .wrInData  (wrInData),
    .rdOutData (rdOutData),
    .wrOutData (wrOutData)
  );

  assign rdInReady  = inReady[CH_RD];
  assign wrInReady  = inReady[CH_WR];
  assign rdOutValid = outValid[CH_RD];
  assign wrOutValid = outValid[CH_WR];
endmodule

// File: rtl/revcorr_chk.sv
module revcorr_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeLoad,
  input logic              modeValue,
  input logic              rdInValid,
  input logic              rdInReady,
  input logic [WORD_W-1:0] rdInData,
  input logic              rdInReverse,
  input logic              rdOutValid,
  input logic              rdOutReady,
  input logic [WORD_W-1:0] rdOutData,
  input logic              wrInValid,
  input logic              wrInReady,
  input logic [WORD_W-1:0] wrInData,
  input logic              wrInReverse,
  input logic              wrOutValid,
  input logic              wrOutReady,
  input logic [WORD_W-1:0] wrOutData
);
  logic modeSeen;
  logic rdAcc;
  logic wrAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeSeen <= 1'b0;
    else if (modeLoad) modeSeen <= modeValue;
  end

  assign rdAcc = rdInValid && rdInReady;
  assign wrAcc = wrInValid && wrInReady;

  AST_RD_FWD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && !rdInReverse |=> rdOutData == $past(rdInData)); // R1
  AST_RD_RAW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc && rdInReverse && !modeSeen |=> rdOutData == $past(rdInData)); // R3
  AST_RD_DUE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc |=> rdOutValid); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdOutValid && !rdOutReady |=> rdOutValid && $stable(rdOutData)); // R7
  AST_RD_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    rdOutValid && !rdOutReady |-> !rdInReady); // R8
  AST_WR_FWD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc && !wrInReverse |=> wrOutData == $past(wrInData)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrOutValid && !wrOutReady |=> wrOutValid && $stable(wrOutData)); // R9
  AST_WR_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    wrOutValid && !wrOutReady |-> !wrInReady); // R9
  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rstN |=> !rdOutValid && !wrOutValid); // R11
endmodule

bind revcorr_top revcorr_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeValue(modeValue),
  .rdInValid(rdInValid), .rdInReady(rdInReady), .rdInData(rdInData),
  .rdInReverse(rdInReverse), .rdOutValid(rdOutValid), .rdOutReady(rdOutReady),
  .rdOutData(rdOutData), .wrInValid(wrInValid), .wrInReady(wrInReady),
  .wrInData(wrInData), .wrInReverse(wrInReverse), .wrOutValid(wrOutValid),
  .wrOutReady(wrOutReady), .wrOutData(wrOutData)
);

// File: tb/revcorr_top_tb_top.sv
`timescale 1ns/1ps
module revcorr_top_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeLoad = 1'b0, modeValue = 1'b0;
  logic rdInValid = 1'b0, rdInReverse = 1'b0, rdOutReady = 1'b1;
  logic wrInValid = 1'b0, wrInReverse = 1'b0, wrOutReady = 1'b1;
  logic [W-1:0] rdInData = '0, wrInData = '0;
  logic rdInReady, rdOutValid, wrInReady, wrOutValid;
  logic [W-1:0] rdOutData, wrOutData;

  int tests = 0, fails = 0;
  logic modeModel = 1'b0;
  logic rdStall = 1'b0, wrStall = 1'b0;
  logic [W-1:0] rdQ[$];
  logic [W-1:0] wrQ[$];
  string rdTag[$];
  string wrTag[$];

  always #5 clk = ~clk;

  revcorr_top dut_i (.*);

  function automatic logic [W-1:0] obv(input logic [W-1:0] w);
    logic [W-1:0] r;
    for (int i = 0; i < 4; i++) r[3*(3-i) +: 3] = 3'd7 - w[3*i +: 3];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  // read-side monitor: takes words unless stalled, compares against queue
  initial forever begin
    @(negedge clk);
    rdOutReady = !rdStall;
    #1;
    if (rstN && rdOutValid && rdOutReady) begin
      if (rdQ.size() == 0) check("R8 rd extra word", rdOutData, 'x);
      else check(rdTag.pop_front(), rdOutData, rdQ.pop_front());
    end
  end

  initial forever begin
    @(negedge clk);
    wrOutReady = !wrStall;
    #1;
    if (rstN && wrOutValid && wrOutReady) begin
      if (wrQ.size() == 0) check("R9 wr extra word", wrOutData, 'x);
      else check(wrTag.pop_front(), wrOutData, wrQ.pop_front());
    end
  end

  // drive one read word; loadMode pulses a mode change in the first cycle
  task automatic sendRd(input logic [W-1:0] d, input logic rev, input string req,
                        input logic loadMode = 1'b0, input logic newMode = 1'b0);
    bit acc = 0;
    @(negedge clk);
    rdInValid = 1; rdInData = d; rdInReverse = rev;
    modeLoad = loadMode; modeValue = newMode;
    while (!acc) begin
      #2;
      acc = rdInReady;
      if (acc) begin
        rdQ.push_back((rev && modeModel) ? obv(d) : d);
        rdTag.push_back(req);
      end
      if (modeLoad) modeModel = modeValue;
      @(negedge clk);
      modeLoad = 0;
    end
    rdInValid = 0;
  endtask

  task automatic sendWr(input logic [W-1:0] d, input logic rev, input logic [W-1:0] exp,
                        input string req);
    bit acc = 0;
    @(negedge clk);
    wrInValid = 1; wrInData = d; wrInReverse = rev;
    while (!acc) begin
      #2;
      acc = wrInReady;
      if (acc) begin
        wrQ.push_back(exp);
        wrTag.push_back(req);
      end
      @(negedge clk);
    end
    wrInValid = 0;
  endtask

  task automatic setMode(input logic v);
    @(negedge clk);
    modeLoad = 1; modeValue = v;
    @(negedge clk);
    modeLoad = 0; modeModel = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R11 rd valid in reset", {11'b0, rdOutValid}, 12'd0);
    check("R11 wr valid in reset", {11'b0, wrOutValid}, 12'd0);
    @(negedge clk); rstN = 1;

    // R4: reverse word right after reset passes raw
    sendRd(12'o1234, 1, "R4 default raw");
    // R1 forward words
    sendRd(12'o7070, 0, "R1 forward");
    sendRd(12'o0001, 0, "R1 forward");
    // R5: load on same edge as acceptance uses old (off) mode
    sendRd(12'o4567, 1, "R5 same-edge old mode", 1'b1, 1'b1);
    // R2: correction now on
    sendRd(12'o1234, 1, "R2 corrected");
    sendRd(12'o0000, 1, "R2 corrected zero");
    sendRd(12'o7777, 0, "R1 forward with corr on");
    // R7 latency: accepted word valid immediately after edge
    @(negedge clk);
    rdInValid = 1; rdInData = 12'o2525; rdInReverse = 0;
    #2; rdQ.push_back(12'o2525); rdTag.push_back("R7 latency data");
    @(negedge clk); rdInValid = 0; #1;
    check("R7 valid after one edge", {11'b0, rdOutValid}, 12'd1);
    // R6/R8: stall, change direction and mode while word waits
    rdStall = 1;
    sendRd(12'o1357, 1, "R6 held word unchanged");
    fork
      sendRd(12'o2460, 0, "R8 queued behind stall");
      begin
        @(negedge clk); rdInReverse = 0; modeLoad = 1; modeValue = 0;
        @(negedge clk); modeLoad = 0;
        repeat (4) @(negedge clk);
        #1;
        check("R8 input not ready under stall", {11'b0, rdInReady}, 12'd0);
        check("R7 output held under stall", rdOutData, obv(12'o1357));
        rdStall = 0;
      end
    join
    modeModel = 0;
    sendRd(12'o1234, 1, "R3 raw when off");
    // R9 write channel, independent stall
    setMode(1);
    sendWr(12'o6543, 0, 12'o6543, "R9 wr forward");
    sendWr(12'o1234, 1, 12'o3456, "R9 wr corrected");
    // R10 round trip: corrected word corrected again returns original
    sendWr(obv(12'o5201), 1, 12'o5201, "R10 round trip");
    wrStall = 1;
    sendWr(12'o0707, 1, 12'o0707 ^ 12'o0, "R9 wr held");
    fork
      sendRd(12'o3333, 1, "R9 rd flows while wr stalled");
      begin repeat (4) @(negedge clk); wrStall = 0; end
    join
    setMode(0);
    sendWr(12'o1234, 1, 12'o1234, "R9 wr raw when off");
    repeat (5) @(negedge clk);
    check("R8 rd queue drained", W'(rdQ.size()), '0);
    check("R9 wr queue drained", W'(wrQ.size()), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule